// File: doc/BRIEF.md
# SDRAM Auto-Precharge Interruption Tracker

This block runs next to the command path of a four-bank SDRAM controller. On every clock it looks at the command being registered: NOP, ACTIVATE, READ or WRITE. READ and WRITE each come with or without auto precharge. It tracks which bank owns the burst in flight and when each burst owns the data bus. It also tracks the state of every bank: idle, open, waiting for an auto precharge, or precharging.

A READ or WRITE to a different bank can cut short a burst that carries auto precharge. When that happens, the tracker pulls in the precharge of the bank that was cut off. The precharge is timed from the clock on which the new command is registered, not from the end of the original burst. An interrupted read bank starts its precharge on that same clock. An interrupted write bank waits the write-recovery time first. When a WRITE cuts off a READ, the tracker checks that the data mask was raised early enough and flags bus contention if it was not. Commands that address a bank in the wrong state are flagged and otherwise dropped.

In the requirements, "after edge k" means the clock cycle that follows rising edge k. Edge e0 is the edge that registers the command in question. The parameters are BL (burst length), CL (2 or 3), TWR and TRP.

Top module: `sdram_ap_tracker`

## Requirements
- R1: While rst_ni is low, idle_o is all ones and pre_start_o, bus_rd_o, bus_wr_o, bus_bank_o, contention_o and illegal_o are zero.
- R2: cmd_i uses 00 for NOP, 01 for ACTIVATE, 10 for READ and 11 for WRITE. ap_i=1 selects auto precharge and bank_i selects the bank. An ACTIVATE to an idle bank opens it, so idle_o for that bank drops after e0.
- R3: A READ to an open bank that nothing interrupts gives BL beats with bus_rd_o=1 and bus_bank_o set to that bank. The beats appear after edges e0+CL through e0+CL+BL-1.
- R4: A WRITE to an open bank that nothing interrupts gives BL beats with bus_wr_o=1 and bus_bank_o set to that bank. The beats appear after edges e0 through e0+BL-1.
- R5: When a READ to bank m is registered at edge e1 while an earlier READ burst is still launching beats, the old bank's beats continue through the cycle after e1+CL-1. Bank m's beats start after e1+CL.
- R6: A WRITE registered at e1 while read data is still due cancels every read beat after edge e1, and bus_wr_o starts after e1. contention_o pulses for one cycle after e1 if dqm_i was low at the required edge. That edge is e1-1 when the last READ had no auto precharge and e1-2 when it had auto precharge.
- R7: When a READ or WRITE at e1 cuts off a WRITE burst, the last write beat of the old bank is the one after e1-1. If the new command is a READ, its data follows R3 timing measured from e1.
- R8: When a READ burst with auto precharge on bank n is cut off at e1 by a READ or WRITE to another bank, pre_start_o[n] pulses after e1.
- R9: When a WRITE burst with auto precharge on bank n is cut off at e1 by a READ or WRITE to another bank, pre_start_o[n] pulses after e1+TWR.
- R10: An auto-precharge burst that nothing interrupts pulses pre_start_o after e0+CL+BL for a READ and after e0+BL+TWR for a WRITE. A burst without auto precharge never pulses pre_start_o.
- R11: When pre_start_o[b] pulses after edge p, idle_o[b] rises after edge p+TRP and stays high until the next ACTIVATE to bank b.
- R12: illegal_o pulses for one cycle after e0 for a READ or WRITE to a bank that is not open, and for an ACTIVATE to a bank that is not idle. Such a command leaves the bursts in flight, the bus outputs and every bank's state exactly as they would be after a NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Registered command: 00 NOP, 01 ACTIVATE, 10 READ, 11 WRITE |
| ap_i | input | 1 | Auto precharge for READ or WRITE |
| bank_i | input | BW | Target bank |
| dqm_i | input | 1 | Data mask level on this clock |
| pre_start_o | output | NB | Per-bank precharge-start pulse |
| idle_o | output | NB | Per-bank idle flag |
| bus_rd_o | output | 1 | Read beat owns the data bus |
| bus_wr_o | output | 1 | Write beat owns the data bus |
| bus_bank_o | output | BW | Bank of the beat on the bus, 0 when the bus is free |
| contention_o | output | 1 | Data mask was raised too late before a WRITE that cut off read data |
| illegal_o | output | 1 | Command rejected for bank state |

## Verification
Two kinds of internal fault show up at the ports on different clocks. A wrong burst owner or a mis-loaded burst count shows up on bus_bank_o or on the bus flags, either on the clock after the command (writes) or CL clocks later (reads). A wrong bank state or a wrong precharge countdown appears as a pre_start_o pulse on the wrong clock, then TRP clocks later as a shifted idle_o edge, and then on the next command to that bank as an illegal_o pulse where none is due, or none where one is due. A reference model in the bench steps one clock at a time and compares every output on every cycle. That comparison covers directed interruptions of each kind and a long mixed random sequence.

// File: rtl/sdram_apt_pkg.sv
package sdram_apt_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RD  = 2'b10,
    CMD_WR  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_OPEN,
    BK_APWAIT,
    BK_PRECH
  } bank_st_e;
endpackage

// File: rtl/sdram_apt_bank.sv
module sdram_apt_bank
  import sdram_apt_pkg::*;
#(
  parameter int CW  = 4,
  parameter int TWR = 2,
  parameter int TRP = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          ap_load_i,
  input  logic [CW-1:0] ap_wait_i,
  input  logic          intr_now_i,
  input  logic          intr_twr_i,
  output logic          pre_o,
  output logic          idle_o,
  output logic          open_o
);
  bank_st_e      st_q;
  logic [CW-1:0] cnt_q;
  logic          pre_q;
  logic          fire;

  // interrupted read precharges at once; write reloads tWR
  assign fire = (st_q == BK_APWAIT) &&
                (intr_now_i || (!intr_twr_i && cnt_q == CW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
      pre_q <= 1'b0;
    end else begin
      pre_q <= fire;
      unique case (st_q)
        BK_IDLE: if (act_i) st_q <= BK_OPEN;
        BK_OPEN: if (ap_load_i) begin
          st_q  <= BK_APWAIT;
          cnt_q <= ap_wait_i;
        end
        BK_APWAIT: begin
          if (fire) begin
            st_q  <= BK_PRECH;
            cnt_q <= CW'(TRP);
          end else if (intr_twr_i) begin
            cnt_q <= CW'(TWR);
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        BK_PRECH: begin
          if (cnt_q == CW'(1)) st_q <= BK_IDLE;
          else cnt_q <= cnt_q - CW'(1);
        end
        default: st_q <= BK_IDLE;
      endcase
    end
  end

  assign pre_o  = pre_q;
  assign idle_o = (st_q == BK_IDLE);
  assign open_o = (st_q == BK_OPEN);

  p_act_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> st_q == BK_IDLE);
  p_intr_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_now_i || intr_twr_i) |-> st_q == BK_APWAIT);
  p_apload_open_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_load_i |-> st_q == BK_OPEN);
  p_pre_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q |=> !pre_q && !idle_o);
endmodule

// File: rtl/sdram_apt_rdpipe.sv
module sdram_apt_rdpipe #(
  parameter int CL = 3,
  parameter int BW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_v_i,
  input  logic [BW-1:0] launch_bank_i,
  input  logic          clear_i,
  output logic          out_v_o,
  output logic [BW-1:0] out_bank_o,
  output logic          pend_o
);
  logic [CL:0]   v_q;
  logic [BW-1:0] b_q [CL+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q[0] <= 1'b0;
      b_q[0] <= '0;
    end else begin
      v_q[0] <= launch_v_i && !clear_i;
      b_q[0] <= launch_bank_i;
    end
  end

  for (genvar i = 1; i <= CL; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[i] <= 1'b0;
        b_q[i] <= '0;
      end else begin
        v_q[i] <= v_q[i-1] && !clear_i;
        b_q[i] <= b_q[i-1];
      end
    end
  end

  assign out_v_o    = v_q[CL];
  assign out_bank_o = b_q[CL];
  assign pend_o     = |v_q[CL-1:0];

  p_clear_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !out_v_o && !pend_o);
endmodule

// File: rtl/sdram_apt_burst.sv
module sdram_apt_burst #(
  parameter int BL = 4,
  parameter int BW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          legal_rd_i,
  input  logic          legal_wr_i,
  input  logic          ap_i,
  input  logic [BW-1:0] bank_i,
  input  logic          dqm_i,
  input  logic          rd_pend_i,
  output logic          busy_o,
  output logic [BW-1:0] cur_bank_o,
  output logic          cur_rd_o,
  output logic          cur_ap_o,
  output logic          launch_v_o,
  output logic [BW-1:0] launch_bank_o,
  output logic          wr_v_o,
  output logic [BW-1:0] wr_bank_o,
  output logic          contention_o
);
  localparam int CNTW = $clog2(BL + 1);

  logic [CNTW-1:0] cnt_q;
  logic [BW-1:0]   cur_bank_q, wr_bank_q;
  logic            cur_rd_q, cur_ap_q, rd_ap_q;
  logic            dqm_d1_q, dqm_d2_q, wr_v_q, cont_q;
  logic            legal_rw, busy, wr_beat, rd_due, dqm_ok;

  assign legal_rw = legal_rd_i || legal_wr_i;
  assign busy     = (cnt_q != '0);

  assign launch_v_o    = legal_rd_i || (busy && cur_rd_q && !legal_rw);
  assign launch_bank_o = legal_rd_i ? bank_i : cur_bank_q;
  assign wr_beat       = legal_wr_i || (busy && !cur_rd_q && !legal_rw);
  assign rd_due        = rd_pend_i || (busy && cur_rd_q);
  // mask lead time depends on the read being cut off
  assign dqm_ok        = rd_ap_q ? dqm_d2_q : dqm_d1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      cur_bank_q <= '0;
      cur_rd_q   <= 1'b0;
      cur_ap_q   <= 1'b0;
      rd_ap_q    <= 1'b0;
      dqm_d1_q   <= 1'b0;
      dqm_d2_q   <= 1'b0;
      wr_v_q     <= 1'b0;
      wr_bank_q  <= '0;
      cont_q     <= 1'b0;
    end else begin
      if (legal_rw) begin
        cnt_q      <= CNTW'(BL - 1);
        cur_bank_q <= bank_i;
        cur_rd_q   <= legal_rd_i;
        cur_ap_q   <= ap_i;
      end else if (busy) begin
        cnt_q <= cnt_q - CNTW'(1);
      end
      if (legal_rd_i) rd_ap_q <= ap_i;
      dqm_d1_q  <= dqm_i;
      dqm_d2_q  <= dqm_d1_q;
      wr_v_q    <= wr_beat;
      wr_bank_q <= legal_wr_i ? bank_i : cur_bank_q;
      cont_q    <= legal_wr_i && rd_due && !dqm_ok;
    end
  end

  assign busy_o       = busy;
  assign cur_bank_o   = cur_bank_q;
  assign cur_rd_o     = cur_rd_q;
  assign cur_ap_o     = cur_ap_q;
  assign wr_v_o       = wr_v_q;
  assign wr_bank_o    = wr_bank_q;
  assign contention_o = cont_q;

  p_one_owner_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(legal_rd_i && legal_wr_i));
  p_rd_stops_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_rd_i |=> !wr_v_o);
endmodule

// File: rtl/sdram_ap_tracker.sv
module sdram_ap_tracker
  import sdram_apt_pkg::*;
#(
  parameter int NB  = 4,
  parameter int BL  = 4,
  parameter int CL  = 3,
  parameter int TWR = 2,
  parameter int TRP = 3,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cmd_i,
  input  logic          ap_i,
  input  logic [BW-1:0] bank_i,
  input  logic          dqm_i,
  output logic [NB-1:0] pre_start_o,
  output logic [NB-1:0] idle_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic [BW-1:0] bus_bank_o,
  output logic          contention_o,
  output logic          illegal_o
);
  localparam int CW = $clog2(CL + BL + TWR + TRP + 2);

  cmd_e          cmd;
  logic [NB-1:0] bk_open, bk_idle, bk_pre;
  logic          tgt_open, tgt_idle;
  logic          legal_act, legal_rd, legal_wr, legal_rw, illegal, illegal_q;
  logic          busy, cur_rd, cur_ap, intr_v;
  logic [BW-1:0] cur_bank;
  logic          launch_v, wr_v, rd_v, rd_pend;
  logic [BW-1:0] launch_bank, wr_bank, rd_bank;
  logic [CW-1:0] ap_wait;

  assign cmd      = cmd_e'(cmd_i);
  assign tgt_open = bk_open[bank_i];
  assign tgt_idle = bk_idle[bank_i];

  assign legal_act = (cmd == CMD_ACT) && tgt_idle;
  assign legal_rd  = (cmd == CMD_RD) && tgt_open;
  assign legal_wr  = (cmd == CMD_WR) && tgt_open;
  assign legal_rw  = legal_rd || legal_wr;
  assign illegal   = ((cmd == CMD_ACT) && !tgt_idle) ||
                     ((cmd == CMD_RD || cmd == CMD_WR) && !tgt_open);

  // new column command to another bank cuts an auto-precharge burst
  assign intr_v  = legal_rw && busy && cur_ap && (cur_bank != bank_i);
  assign ap_wait = legal_rd ? CW'(CL + BL) : CW'(BL + TWR);

  sdram_apt_burst #(.BL(BL), .BW(BW)) i_burst (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .legal_rd_i    (legal_rd),
    .legal_wr_i    (legal_wr),
    .ap_i          (ap_i),
    .bank_i        (bank_i),
    .dqm_i         (dqm_i),
    .rd_pend_i     (rd_pend),
    .busy_o        (busy),
    .cur_bank_o    (cur_bank),
    .cur_rd_o      (cur_rd),
    .cur_ap_o      (cur_ap),
    .launch_v_o    (launch_v),
    .launch_bank_o (launch_bank),
    .wr_v_o        (wr_v),
    .wr_bank_o     (wr_bank),
    .contention_o  (contention_o)
  );

  sdram_apt_rdpipe #(.CL(CL), .BW(BW)) i_rdpipe (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_v_i    (launch_v),
    .launch_bank_i (launch_bank),
    .clear_i       (legal_wr),
    .out_v_o       (rd_v),
    .out_bank_o    (rd_bank),
    .pend_o        (rd_pend)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel, cur_sel;
    assign sel     = (bank_i == BW'(b));
    assign cur_sel = (cur_bank == BW'(b));

    sdram_apt_bank #(.CW(CW), .TWR(TWR), .TRP(TRP)) i_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (legal_act && sel),
      .ap_load_i  (legal_rw && ap_i && sel),
      .ap_wait_i  (ap_wait),
      .intr_now_i (intr_v && cur_rd && cur_sel),
      .intr_twr_i (intr_v && !cur_rd && cur_sel),
      .pre_o      (bk_pre[b]),
      .idle_o     (bk_idle[b]),
      .open_o     (bk_open[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else illegal_q <= illegal;
  end

  assign pre_start_o = bk_pre;
  assign idle_o      = bk_idle;
  assign bus_rd_o    = rd_v;
  assign bus_wr_o    = wr_v;
  assign bus_bank_o  = wr_v ? wr_bank : (rd_v ? rd_bank : '0);
  assign illegal_o   = illegal_q;

  p_bus_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));
  p_illegal_no_wr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal && !busy) |=> !bus_wr_o);
endmodule

// File: tb/test_sdram_ap_tracker.sv
module test_sdram_ap_tracker;
  localparam int NB  = 4;
  localparam int BL  = 4;
  localparam int CL  = 3;
  localparam int TWR = 2;
  localparam int TRP = 3;
  localparam int BW  = $clog2(NB);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    cmd_i = 2'b00;
  logic          ap_i = 1'b0;
  logic [BW-1:0] bank_i = '0;
  logic          dqm_i = 1'b0;
  logic [NB-1:0] pre_start_o, idle_o;
  logic          bus_rd_o, bus_wr_o, contention_o, illegal_o;
  logic [BW-1:0] bus_bank_o;

  always #2 clk_i = ~clk_i;

  sdram_ap_tracker #(.NB(NB), .BL(BL), .CL(CL), .TWR(TWR), .TRP(TRP)) i_sdram_ap_tracker (
    .clk_i, .rst_ni, .cmd_i, .ap_i, .bank_i, .dqm_i,
    .pre_start_o, .idle_o, .bus_rd_o, .bus_wr_o, .bus_bank_o,
    .contention_o, .illegal_o
  );

  int    n_chk = 0, n_bad = 0;
  string tag = "R1";

  // reference model, states: 0 idle, 1 open, 2 waiting auto precharge, 3 precharging
  int m_st [NB];
  int m_pre_ev [NB];
  int m_idle_ev [NB];
  int cur_bank, cur_end, cur_rd, cur_ap, rd_ap, k;
  bit dq1, dq2;
  bit rv [16];
  int rb [16];
  int e_rd, e_wr, e_bank, e_ill, e_cont, e_pre, e_idle;

  function automatic void chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < NB; i++) begin
      m_st[i] = 0; m_pre_ev[i] = -1; m_idle_ev[i] = -1;
    end
    for (int i = 0; i < 16; i++) begin rv[i] = 0; rb[i] = 0; end
    cur_bank = 0; cur_end = -1; cur_rd = 0; cur_ap = 0; rd_ap = 0;
    dq1 = 0; dq2 = 0; k = 0;
  endfunction

  function automatic void model_edge(int c, int ap, int b, int dq);
    bit lact, lrd, lwr, rw, busy, pend;
    int launch, wb, rdb;
    lact = (c == 1) && (m_st[b] == 0);
    lrd  = (c == 2) && (m_st[b] == 1);
    lwr  = (c == 3) && (m_st[b] == 1);
    rw   = lrd || lwr;
    e_ill = ((c == 1) && (m_st[b] != 0)) || ((c >= 2) && (m_st[b] != 1));
    busy = (k <= cur_end);
    pend = busy && (cur_rd != 0);
    for (int t = k; t < k + CL; t++) pend |= rv[t % 16];
    e_cont = lwr && pend && !(rd_ap != 0 ? dq2 : dq1);
    if (rw && busy && cur_ap != 0 && cur_bank != b)
      m_pre_ev[cur_bank] = (cur_rd != 0) ? k : k + TWR;
    launch = -1; e_wr = 0; wb = 0;
    if (lrd) launch = b;
    else if (busy && cur_rd != 0 && !rw) launch = cur_bank;
    if (lwr) begin e_wr = 1; wb = b; end
    else if (busy && cur_rd == 0 && !rw) begin e_wr = 1; wb = cur_bank; end
    if (lwr) for (int t = k; t <= k + CL; t++) rv[t % 16] = 0;
    e_rd = rv[k % 16]; rdb = rb[k % 16]; rv[k % 16] = 0;
    if (launch >= 0) begin rv[(k + CL) % 16] = 1; rb[(k + CL) % 16] = launch; end
    e_bank = e_wr != 0 ? wb : (e_rd != 0 ? rdb : 0);
    if (rw) begin
      cur_bank = b; cur_end = k + BL - 1; cur_rd = lrd; cur_ap = ap;
      if (ap != 0) begin
        m_st[b] = 2;
        m_pre_ev[b] = lrd ? k + CL + BL : k + BL + TWR;
      end
    end
    if (lrd) rd_ap = ap;
    if (lact) m_st[b] = 1;
    e_pre = 0; e_idle = 0;
    for (int i = 0; i < NB; i++) begin
      if (m_st[i] == 3 && m_idle_ev[i] == k) m_st[i] = 0;
      if (m_st[i] == 2 && m_pre_ev[i] == k) begin
        e_pre |= (1 << i); m_st[i] = 3; m_idle_ev[i] = k + TRP;
      end
      if (m_st[i] == 0) e_idle |= (1 << i);
    end
    dq2 = dq1; dq1 = dq[0]; k++;
  endfunction

  task automatic step(int c, int ap, int b, int dq);
    cmd_i = 2'(c); ap_i = ap[0]; bank_i = BW'(b); dqm_i = dq[0];
    model_edge(c, ap, b, dq);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("bus_rd_o", int'(bus_rd_o), e_rd);
    chk("bus_wr_o", int'(bus_wr_o), e_wr);
    chk("bus_bank_o", int'(bus_bank_o), e_bank);
    chk("pre_start_o", int'(pre_start_o), e_pre);
    chk("idle_o", int'(idle_o), e_idle);
    chk("illegal_o", int'(illegal_o), e_ill);
    chk("contention_o", int'(contention_o), e_cont);
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int r, c;
    model_reset();
    repeat (3) @(negedge clk_i);
    tag = "R1";
    chk("idle_o reset", int'(idle_o), (1 << NB) - 1);
    chk("pre_start_o reset", int'(pre_start_o), 0);
    chk("bus reset", int'({bus_rd_o, bus_wr_o, bus_bank_o}), 0);
    chk("flags reset", int'({contention_o, illegal_o}), 0);
    rst_ni = 1'b1;

    tag = "R2";  step(1, 0, 0, 0); step(1, 0, 1, 0); step(1, 0, 2, 0); step(1, 0, 3, 0); nops(2);
    tag = "R3";  step(2, 0, 0, 0); nops(10);
    tag = "R4";  step(3, 0, 1, 0); nops(8);
    tag = "R5";  step(2, 0, 0, 0); step(0, 0, 0, 0); step(2, 0, 1, 0); nops(10);
    tag = "R6";  step(2, 1, 2, 0); step(0, 0, 0, 0); step(3, 0, 1, 0); nops(8);
    step(2, 0, 0, 0); step(0, 0, 0, 1); step(3, 0, 1, 0); nops(8);
    step(2, 0, 0, 0); step(0, 0, 0, 0); step(3, 0, 1, 0); nops(8);
    tag = "R7";  step(3, 0, 0, 0); step(0, 0, 0, 0); step(2, 0, 1, 0); nops(8);
    step(3, 0, 0, 0); step(3, 0, 1, 0); nops(8);
    tag = "R8";  step(1, 0, 2, 0); step(2, 1, 2, 0); step(2, 0, 0, 0); nops(10);
    tag = "R9";  step(3, 1, 3, 0); step(0, 0, 0, 0); step(3, 0, 0, 0); nops(10);
    tag = "R10"; step(2, 1, 1, 0); nops(14);
    tag = "R11"; step(1, 0, 1, 0); step(3, 1, 1, 0); nops(14); step(1, 0, 1, 0);
    step(1, 0, 2, 0); step(1, 0, 3, 0); nops(2);
    tag = "R12"; step(2, 0, 0, 0); step(1, 0, 0, 0); step(3, 1, 1, 0);
    step(2, 0, 1, 0); step(2, 1, 1, 0); nops(12); step(3, 0, 1, 0); nops(6);

    tag = "R3/R4 random";
    r = int'($urandom(32'h5eed));
    for (int i = 0; i < 3000; i++) begin
      r = int'($urandom % 8);
      c = (r < 3) ? 0 : (r == 3) ? 1 : (r < 6) ? 2 : 3;
      step(c, int'($urandom % 2), int'($urandom % NB), int'($urandom % 2));
    end
    nops(20);
    summary();
    $finish;
  end
endmodule